// File: doc/BRIEF.md
# Three-Stage 8x Interpolation Filter

This block raises a stereo audio stream from the base sample rate fs to 8fs by passing it through three cascaded rate-doubling FIR stages. The first stage is long (127 taps) and sets the passband. The two later stages (23 and 11 taps) only need to remove the images left by the stages before them. Each stage works in polyphase form: the even output of a pair uses the even-indexed taps, the odd output uses the odd-indexed taps, and no multiplications by stuffed zeros are done. A single multiply-accumulate unit per stage, clocked by the fast system clock (384fs or 512fs), serves both channels in turn. Each stage keeps a separate delay line for each channel.

Coefficients are design-time parameters, and their design lies outside this block. Each stage rounds its sum to nearest, saturates it to the sample width, and passes it on as a stereo pair with a one-cycle strobe. The input accepts either full 18-bit samples or 16-bit samples, which are scaled up to the same full-scale range.

Top module: `interp8x_top`

## Requirements
- R1: Every accepted input strobe yields exactly eight output strobes, two per stage. Each output strobe carries a left and a right sample. The output order follows the input order.
- R2: Each stage computes y[2n+p] = sum over k of h[2k+p]·x[n-k] for p = 0 (first output of the pair) and p = 1 (second), where h has TAPS entries and entries beyond TAPS-1 count as zero. Coefficient j is an 18-bit signed value with 16 fraction bits, held in bits [18j+17:18j] of the stage's coefficient parameter. The defaults are 127, 23 and 11 taps.
- R3: Each stage output equals (sum + 32768) shifted right arithmetically by 16 bits, which is round-half-up to the nearest integer.
- R4: After rounding, each stage output is clamped to the range -131072..131071.
- R5: When in_wide = 1, in_left/in_right carry an 18-bit two's-complement sample. When in_wide = 0, only bits [15:0] are used: they are read as a 16-bit two's-complement value and multiplied by 4, and bits [17:16] have no effect.
- R6: The left output depends only on left inputs and the right output depends only on right inputs.
- R7: A synchronous active-high reset clears every delay line and the outputs to zero. No output strobe appears after reset until a new input has been accepted.
- R8: out_valid is high for exactly one cycle per output. out_left and out_right change only in a cycle in which out_valid is high, and hold their value between strobes.
- R9: Input strobes must be at least 4·ceil(TAPS1/2)+1 clock cycles apart (257 by default). At that spacing no sample is lost, even when an inner stage receives its next input while it is still busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (384fs or 512fs) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe: a new stereo sample is on the inputs |
| in_wide | input | 1 | 1: 18-bit samples; 0: 16-bit samples in bits [15:0] |
| in_left | input | 18 | Left input sample, two's complement |
| in_right | input | 18 | Right input sample, two's complement |
| out_valid | output | 1 | One-cycle strobe per 8fs output pair |
| out_left | output | 18 | Left output sample |
| out_right | output | 18 | Right output sample |

## Verification
The bench feeds the cascade a set of directed patterns:
- A few isolated impulses: these expose wrong tap order, a swapped polyphase and a wrong output order.
- Long runs of pseudo-random samples: any drift caused by truncation instead of rounding shows up here.
- 16-bit samples with random bits above bit 15, which separate the narrow path from the wide path.
- Left-only stimulus with the right input held at zero, which reveals mixing between the two channels.
- Sustained full-scale positive and negative runs, which drive the clamp in every stage.
- A reset issued mid-burst, which shows whether delay-line contents survive the reset.
- Inputs at the minimum allowed spacing, which load the pending slot of the inner stages.

All outputs are compared against a bench-side cascade model that uses the same coefficient sets. Those sets carry asymmetric per-tap offsets, so a mirrored index or a swapped phase does not cancel out.

// File: rtl/interp_pkg.sv
package interp_pkg;

    localparam int SAMPLE_W  = 18;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 16;
    localparam int MAX_TAPS  = 128;
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    localparam int ACC_W     = PROD_W + 8;
    localparam int BANK_W    = MAX_TAPS * COEF_W;

    typedef logic [BANK_W-1:0] coef_bank_t;

    // MAC work order inside one stage: bit 1 = output phase, bit 0 = channel
    typedef enum logic [1:0] {
        SLOT_P0_L = 2'd0,
        SLOT_P0_R = 2'd1,
        SLOT_P1_L = 2'd2,
        SLOT_P1_R = 2'd3
    } slot_e;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] left;
        logic signed [SAMPLE_W-1:0] right;
    } stereo_t;

    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (COEF_FRAC - 1);
    localparam logic signed [ACC_W-1:0] POS_LIM  = (ACC_W'(1) << (SAMPLE_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] NEG_LIM  = -POS_LIM - ACC_W'(1);

    function automatic int half_len(input int taps);
        return (taps + 1) / 2;
    endfunction

    // Placeholder kernel: linear interpolation centred in the tap window
    function automatic coef_bank_t linear_kernel(input int taps);
        coef_bank_t bank;
        int centre;
        bank   = '0;
        centre = (taps - 1) / 2;
        for (int j = 0; j < taps; j++) begin
            if (j == centre)
                bank[j*COEF_W +: COEF_W] = COEF_W'(1 << COEF_FRAC);
            else if (j == centre - 1 || j == centre + 1)
                bank[j*COEF_W +: COEF_W] = COEF_W'(1 << (COEF_FRAC - 1));
        end
        return bank;
    endfunction

    function automatic logic signed [SAMPLE_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] scaled;
        scaled = (acc + HALF_LSB) >>> COEF_FRAC;
        if (scaled > POS_LIM)
            return POS_LIM[SAMPLE_W-1:0];
        else if (scaled < NEG_LIM)
            return NEG_LIM[SAMPLE_W-1:0];
        else
            return scaled[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/interp_input_align.sv
module interp_input_align
    import interp_pkg::*;
#(
    parameter int NARROW_W = 16
) (
    input  logic                       wide_mode,
    input  logic signed [SAMPLE_W-1:0] raw,
    output logic signed [SAMPLE_W-1:0] aligned
);

    localparam int PAD_W = SAMPLE_W - NARROW_W;

    // Narrow samples are moved to the top of the word: same full scale
    always_comb begin
        if (wide_mode)
            aligned = raw;
        else
            aligned = $signed({raw[NARROW_W-1:0], {PAD_W{1'b0}}});
    end

endmodule

// File: rtl/interp_delay_line.sv
module interp_delay_line
    import interp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic signed [SAMPLE_W-1:0] rd_data
);

    logic signed [SAMPLE_W-1:0] taps_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) taps_q[i] <= '0;
        end else if (shift_en) begin
            taps_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) taps_q[i] <= taps_q[i-1];
        end
    end

    assign rd_data = taps_q[rd_idx];

endmodule

// File: rtl/interp_mac_unit.sv
module interp_mac_unit
    import interp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mac_en,
    input  logic                       mac_first,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [COEF_W-1:0]   coef,
    output logic signed [SAMPLE_W-1:0] result
);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_d;

    assign prod   = PROD_W'(sample) * PROD_W'(coef);
    assign acc_d  = (mac_first ? '0 : acc_q) + ACC_W'(prod);
    assign result = round_sat(acc_d);

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (mac_en)
            acc_q <= acc_d;
    end

endmodule

// File: rtl/interp_stage.sv
module interp_stage
    import interp_pkg::*;
#(
    parameter int         TAPS  = 11,
    parameter coef_bank_t COEFS = linear_kernel(11)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  stereo_t in_smp,
    output logic    out_valid,
    output stereo_t out_smp
);

    localparam int HALF = half_len(TAPS);
    localparam int KW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [KW-1:0] K_LAST = KW'(HALF - 1);

    logic                       busy;
    slot_e                      slot;
    logic [KW-1:0]              k;
    logic                       pend_v;
    stereo_t                    pend_smp;
    logic signed [SAMPLE_W-1:0] left_hold;
    logic                       start;
    stereo_t                    start_smp;
    logic [KW:0]                cidx;
    logic signed [COEF_W-1:0]   coef_sel;
    logic signed [SAMPLE_W-1:0] tap_rd [2];
    logic signed [SAMPLE_W-1:0] sample_sel;
    logic signed [SAMPLE_W-1:0] mac_result;
    logic                       last_k;

    assign start     = !busy && (pend_v || in_valid);
    assign start_smp = pend_v ? pend_smp : in_smp;
    assign last_k    = (k == K_LAST);

    // Polyphase tap index 2k + phase
    assign cidx = {k, slot[1]};

    always_comb begin
        coef_sel = '0;
        if (int'(cidx) < TAPS)
            coef_sel = $signed(COEFS[int'(cidx)*COEF_W +: COEF_W]);
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        interp_delay_line #(
            .DEPTH (HALF),
            .IDX_W (KW)
        ) u_line (
            .clk      (clk),
            .rst      (rst),
            .shift_en (start),
            .din      ((ch == 0) ? start_smp.left : start_smp.right),
            .rd_idx   (k),
            .rd_data  (tap_rd[ch])
        );
    end

    assign sample_sel = slot[0] ? tap_rd[1] : tap_rd[0];

    interp_mac_unit u_mac (
        .clk       (clk),
        .rst       (rst),
        .mac_en    (busy),
        .mac_first (k == '0),
        .sample    (sample_sel),
        .coef      (coef_sel),
        .result    (mac_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            slot      <= SLOT_P0_L;
            k         <= '0;
            pend_v    <= 1'b0;
            pend_smp  <= '0;
            left_hold <= '0;
            out_smp   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                slot <= SLOT_P0_L;
                k    <= '0;
            end
            // one-entry holding slot for an input that lands during a burst
            if (!busy && pend_v) begin
                pend_v   <= in_valid;
                pend_smp <= in_smp;
            end else if (busy && in_valid) begin
                pend_v   <= 1'b1;
                pend_smp <= in_smp;
            end
            if (busy) begin
                if (last_k) begin
                    k <= '0;
                    if (!slot[0]) begin
                        left_hold <= mac_result;
                    end else begin
                        out_smp   <= '{left: left_hold, right: mac_result};
                        out_valid <= 1'b1;
                    end
                    if (slot == SLOT_P1_R)
                        busy <= 1'b0;
                    else
                        slot <= slot_e'(slot + 2'd1);
                end else begin
                    k <= k + 1'b1;
                end
            end
        end
    end

    AST_PEND_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !(busy && pend_v)); // R9

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_smp)); // R8

endmodule

// File: rtl/interp8x_top.sv
module interp8x_top
    import interp_pkg::*;
#(
    parameter int         NARROW_W = 16,
    parameter int         TAPS_S1  = 127,
    parameter int         TAPS_S2  = 23,
    parameter int         TAPS_S3  = 11,
    parameter coef_bank_t COEFS_S1 = linear_kernel(127),
    parameter coef_bank_t COEFS_S2 = linear_kernel(23),
    parameter coef_bank_t COEFS_S3 = linear_kernel(11)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_wide,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);

    localparam int N_STAGES = 3;
    localparam int MIN_GAP  = 4 * half_len(TAPS_S1) + 1;
    localparam int GAP_W    = $clog2(MIN_GAP + 1);

    stereo_t [N_STAGES:0] link;
    logic    [N_STAGES:0] link_v;

    interp_input_align #(.NARROW_W(NARROW_W)) u_align_l (
        .wide_mode (in_wide),
        .raw       (in_left),
        .aligned   (link[0].left)
    );

    interp_input_align #(.NARROW_W(NARROW_W)) u_align_r (
        .wide_mode (in_wide),
        .raw       (in_right),
        .aligned   (link[0].right)
    );

    assign link_v[0] = in_valid;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        localparam int         S_TAPS  = (s == 0) ? TAPS_S1 : (s == 1) ? TAPS_S2 : TAPS_S3;
        localparam coef_bank_t S_COEFS = (s == 0) ? COEFS_S1 : (s == 1) ? COEFS_S2 : COEFS_S3;

        interp_stage #(
            .TAPS  (S_TAPS),
            .COEFS (S_COEFS)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (link_v[s]),
            .in_smp    (link[s]),
            .out_valid (link_v[s+1]),
            .out_smp   (link[s+1])
        );
    end

    assign out_valid = link_v[N_STAGES];
    assign out_left  = link[N_STAGES].left;
    assign out_right = link[N_STAGES].right;

    // Input-spacing and post-reset observers
    logic [GAP_W-1:0] gap_q;
    logic             primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q    <= GAP_W'(MIN_GAP);
            primed_q <= 1'b0;
        end else begin
            if (in_valid) begin
                gap_q    <= GAP_W'(1);
                primed_q <= 1'b1;
            end else if (gap_q < GAP_W'(MIN_GAP)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_INPUT_GAP: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (gap_q >= GAP_W'(MIN_GAP))); // R9

    AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> primed_q); // R7

endmodule

// File: tb/test_interp8x_top.sv
`timescale 1ns/1ps
module test_interp8x_top;
    import interp_pkg::*;

    localparam int T1 = 127;
    localparam int T2 = 23;
    localparam int T3 = 11;
    localparam int MIN_GAP = 4 * ((T1 + 1) / 2) + 1;
    localparam int GAP = 260;
    localparam longint SMAX = 131071;
    localparam longint SMIN = -131072;

    function automatic int tb_taps(input int s);
        return (s == 0) ? T1 : (s == 1) ? T2 : T3;
    endfunction

    // Linear kernel plus asymmetric positive offsets per tap
    function automatic int tb_coef(input int s, input int j);
        int c;
        int base;
        c = (tb_taps(s) - 1) / 2;
        base = (j == c) ? 65536 : ((j == c - 1) || (j == c + 1)) ? 32768 : 0;
        return base + ((j * 29 + s * 7) % 23) * 40;
    endfunction

    function automatic coef_bank_t tb_bank(input int s);
        coef_bank_t b;
        b = '0;
        for (int j = 0; j < tb_taps(s); j++) b[j*COEF_W +: COEF_W] = COEF_W'(tb_coef(s, j));
        return b;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_wide = 1'b1;
    logic signed [17:0] in_left = '0;
    logic signed [17:0] in_right = '0;
    logic out_valid;
    logic signed [17:0] out_left;
    logic signed [17:0] out_right;

    always #2.5 clk = ~clk;

    interp8x_top #(
        .TAPS_S1 (T1), .TAPS_S2 (T2), .TAPS_S3 (T3),
        .COEFS_S1 (tb_bank(0)), .COEFS_S2 (tb_bank(1)), .COEFS_S3 (tb_bank(2))
    ) i_interp8x_top (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_wide (in_wide),
        .in_left (in_left), .in_right (in_right),
        .out_valid (out_valid), .out_left (out_left), .out_right (out_right)
    );

    int checks = 0;
    int bad = 0;
    int strobes = 0;
    bit done = 0;
    string cur_req = "R2";
    longint exp_l[$];
    longint exp_r[$];
    longint m_dl[3][2][64];
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // ---------------- reference cascade ----------------
    function automatic longint m_round(input longint acc);
        longint v;
        v = (acc + 32768) >>> 16;
        if (v > SMAX) v = SMAX;
        if (v < SMIN) v = SMIN;
        return v;
    endfunction

    task automatic m_stage(input int s, input longint xl, input longint xr,
                           output longint l0, output longint l1,
                           output longint r0, output longint r1);
        longint acc[2][2];
        for (int c = 0; c < 2; c++) begin
            for (int i = 63; i > 0; i--) m_dl[s][c][i] = m_dl[s][c][i-1];
        end
        m_dl[s][0][0] = xl;
        m_dl[s][1][0] = xr;
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 2; c++) begin
                acc[p][c] = 0;
                for (int k = 0; 2 * k + p < tb_taps(s); k++)
                    acc[p][c] += longint'(tb_coef(s, 2 * k + p)) * m_dl[s][c][k];
            end
        end
        l0 = m_round(acc[0][0]); r0 = m_round(acc[0][1]);
        l1 = m_round(acc[1][0]); r1 = m_round(acc[1][1]);
    endtask

    task automatic m_push(input longint xl, input longint xr);
        longint a[4];
        longint b[4];
        longint c[4];
        m_stage(0, xl, xr, a[0], a[1], a[2], a[3]);
        for (int p1 = 0; p1 < 2; p1++) begin
            m_stage(1, a[p1], a[2 + p1], b[0], b[1], b[2], b[3]);
            for (int p2 = 0; p2 < 2; p2++) begin
                m_stage(2, b[p2], b[2 + p2], c[0], c[1], c[2], c[3]);
                exp_l.push_back(c[0]); exp_r.push_back(c[2]);
                exp_l.push_back(c[1]); exp_r.push_back(c[3]);
            end
        end
    endtask

    task automatic m_clear();
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < 64; i++) m_dl[s][c][i] = 0;
        exp_l.delete();
        exp_r.delete();
    endtask

    // ---------------- output monitor ----------------
    bit prev_v = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_v = 0;
        end else begin
            if (out_valid) begin
                strobes++;
                chk(!prev_v, "R8", "strobe longer than one cycle", 1, 0);
                if (exp_l.size() == 0) begin
                    chk(0, "R1", "strobe with no expected output", strobes, 0);
                end else begin
                    longint el;
                    longint er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    chk(longint'(out_left) == el, cur_req, "left sample", longint'(out_left), el);
                    chk(longint'(out_right) == er, cur_req, "right sample", longint'(out_right), er);
                end
            end
            prev_v = out_valid;
        end
    end

    // ---------------- drivers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic signed [17:0] l, input logic signed [17:0] r,
                        input logic wide, input int gap);
        longint ml;
        longint mr;
        ml = wide ? longint'(l) : longint'($signed(l[15:0])) * 4;
        mr = wide ? longint'(r) : longint'($signed(r[15:0])) * 4;
        m_push(ml, mr);
        @(negedge clk);
        in_valid = 1'b1; in_wide = wide; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    function automatic logic signed [17:0] rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return 18'(($signed({1'b0, seed[31:16]}) - 32768) / 2);
    endfunction

    task automatic drain(input int n_in, input int strobes_before);
        repeat (400) @(negedge clk);
        chk(exp_l.size() == 0, "R1", "outputs still outstanding", exp_l.size(), 0);
        chk(strobes - strobes_before == 8 * n_in, "R1", "strobe count",
            strobes - strobes_before, 8 * n_in);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        int s0;
        s0 = strobes;
        repeat (100) @(negedge clk);
        chk(out_left == 0, "R7", "left after reset", out_left, 0);
        chk(out_right == 0, "R7", "right after reset", out_right, 0);
        chk(strobes == s0, "R7", "strobes before first input", strobes - s0, 0);
    endtask

    task automatic t_impulse();
        int s0;
        cur_req = "R2";
        s0 = strobes;
        send(18'sd20000, -18'sd12345, 1'b1, GAP);
        for (int i = 0; i < 5; i++) send(18'sd0, 18'sd0, 1'b1, GAP);
        send(-18'sd7001, 18'sd30001, 1'b1, GAP);
        send(18'sd0, 18'sd0, 1'b1, GAP);
        drain(8, s0);
    endtask

    task automatic t_random();
        int s0;
        cur_req = "R3";
        s0 = strobes;
        for (int i = 0; i < 40; i++) send(rnd16(), rnd16(), 1'b1, GAP);
        drain(40, s0);
    endtask

    task automatic t_narrow();
        int s0;
        cur_req = "R5";
        s0 = strobes;
        for (int i = 0; i < 12; i++) begin
            logic signed [17:0] l;
            logic signed [17:0] r;
            l = rnd16();
            r = rnd16();
            l[17:16] = seed[3:2];
            r[17:16] = seed[5:4];
            send(l, r, 1'b0, GAP);
        end
        drain(12, s0);
    endtask

    task automatic t_channels();
        int s0;
        do_reset();
        cur_req = "R6";
        s0 = strobes;
        for (int i = 0; i < 8; i++) send(rnd16(), 18'sd0, 1'b1, GAP);
        drain(8, s0);
    endtask

    task automatic t_saturate();
        int s0;
        do_reset();
        cur_req = "R4";
        s0 = strobes;
        for (int i = 0; i < 70; i++) send(18'sd131071, 18'sd131071, 1'b1, GAP);
        drain(70, s0);
        chk(longint'(out_left) == SMAX, "R4", "left clamp high", out_left, SMAX);
        chk(longint'(out_right) == SMAX, "R4", "right clamp high", out_right, SMAX);
        s0 = strobes;
        for (int i = 0; i < 70; i++) send(-18'sd131072, -18'sd131072, 1'b1, GAP);
        drain(70, s0);
        chk(longint'(out_left) == SMIN, "R4", "left clamp low", out_left, SMIN);
        chk(longint'(out_right) == SMIN, "R4", "right clamp low", out_right, SMIN);
    endtask

    task automatic t_mid_reset();
        int s0;
        cur_req = "R7";
        send(18'sd25000, -18'sd25000, 1'b1, GAP);
        send(18'sd9000, 18'sd4000, 1'b1, 60);
        do_reset();
        s0 = strobes;
        repeat (400) @(negedge clk);
        chk(strobes == s0, "R7", "strobes after mid-run reset", strobes - s0, 0);
        chk(out_left == 0, "R7", "left cleared", out_left, 0);
        chk(out_right == 0, "R7", "right cleared", out_right, 0);
        send(18'sd15000, 18'sd3000, 1'b1, GAP);
        for (int i = 0; i < 3; i++) send(18'sd0, 18'sd0, 1'b1, GAP);
        drain(4, s0);
    endtask

    task automatic t_min_gap();
        int s0;
        cur_req = "R9";
        s0 = strobes;
        for (int i = 0; i < 12; i++) send(rnd16(), rnd16(), 1'b1, MIN_GAP);
        drain(12, s0);
    endtask

    initial begin
        m_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_impulse();
        t_random();
        t_narrow();
        t_channels();
        t_saturate();
        t_mid_reset();
        t_min_gap();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule